// File: doc/BRIEF.md
# Chained Descriptor Receive DMA

This block moves received frames from a serial receiver into a shared memory, one descriptor at a time. The host builds a ring of descriptors in that memory. Each descriptor names the next descriptor and a data buffer, and has room for a length and a status byte. The host then programs where the engine starts, where it must stop and how many bytes a buffer can hold, and sets the enable bit. From then on the engine needs no help from the host. It reads a descriptor, fills its buffer from the byte stream, writes back the length and the status, and follows the chain pointer to the next descriptor.

A frame larger than one buffer continues in the next descriptor. Only the descriptor holding the last byte of the frame is marked as the end of the message. Before it reads each new descriptor, the engine compares the current descriptor address with the end address. If they are equal, the engine halts and flags a buffer overflow, so it never runs over descriptors the host has not yet released. The host can move the end address on and enable the channel again, and reception resumes where it stopped. An interrupt line reports completed frames and overflow.

Descriptor layout, for an address width of 16 bits (AB = address bytes, little-endian throughout):

| Offset | Content |
|---|---|
| 0 to AB-1 | next descriptor address |
| AB to 2AB-1 | buffer address |
| 2AB to 2AB+1 | byte count |
| 2AB+2 | status byte |

Status byte: bit 0 = end of message; bit 1 = CRC error; bit 2 = overrun; bit 3 = short frame; bit 4 = abort; bit 5 = residual bits. Input `rx_err[0..4]` maps, in that order, onto status bits 1..5.

Host register addresses:

| Address | Register |
|---|---|
| 0 | current descriptor |
| 1 | end descriptor |
| 2 | buffer length |
| 3 | control/status |
| 4 | interrupt enable |
| 5 | frame counter (read only) |
| 6 | command |

Control/status bits: bit 0 = enable; bit 1 = clear qualifier; bit 2 = end of transfer; bit 3 = end of message; bit 4 = buffer overflow; bit 5 = counter overflow.

Interrupt enable bits: bit 0 = end of message; bit 1 = buffer overflow.

Command bits (write only): bit 0 = abort; bit 1 = clear the frame counter.

Top module: `rx_desc_dma`

## Requirements
- R1: After reset the following all read as zero or are low: the enable bit, all status flags, the frame counter, `irq`, `mem_req` and `rx_ready`.
- R2: After fetching a descriptor, the engine writes the n-th byte of its buffer fill to the buffer address plus n. The buffer address is the one read from the descriptor.
- R3: After a descriptor is written back, the current-descriptor register holds that descriptor's chain pointer. The next frame goes to the next descriptor without any host action, and this includes wrapping from the last ring entry to the first.
- R4: When a frame ends, the engine writes the byte count to the descriptor's length field and then writes the status byte. The status byte is 0x01 OR'd with `rx_err` shifted left by one.
- R5: A buffer receives no more bytes than the buffer length register allows. When a frame reaches that limit, the engine writes back the full length with status 0x00 and continues the frame in the next descriptor.
- R6: Before each descriptor fetch, the engine compares the current and end addresses. If they are equal, it makes no memory access, sets end-of-transfer and buffer overflow, clears enable and holds `rx_ready` low.
- R7: A control write with bit 1 set clears the status flags written as one and leaves enable unchanged. A control write with bit 1 clear sets enable to bit 0 and leaves the flags unchanged.
- R8: While enable is zero, the engine accepts no received bytes. A partly filled buffer continues at the same offset once the channel is enabled again.
- R9: `irq` is high exactly when end-of-message is set and its enable bit is set, or when buffer overflow is set and its enable bit is set.
- R10: The frame counter counts each completed frame once, however many descriptors the frame spans. The clear command sets it to zero. Wrapping past its maximum sets counter overflow.
- R11: The abort command clears enable and all status flags and drops any partial buffer. The next enable fetches the current descriptor again and starts filling at offset 0.
- R12: Only one memory access is outstanding at a time. Request, address, direction and write data stay stable until grant.
- R13: After a halt on buffer overflow, the host can move the end address on, clear the flags and enable the channel. Reception then continues at the descriptor where the engine halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| reg_we | input | 1 | host register write strobe |
| reg_addr | input | 3 | host register address |
| reg_wdata | input | ADDR_W | host write data |
| reg_rdata | output | ADDR_W | host read data (combinational from reg_addr) |
| rx_valid | input | 1 | received byte present |
| rx_ready | output | 1 | engine takes the byte this cycle |
| rx_data | input | 8 | received byte |
| rx_eof | input | 1 | byte is the last of its frame |
| rx_err | input | 5 | frame error flags, valid with rx_eof |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | ADDR_W | memory byte address |
| mem_wdata | output | 8 | write byte |
| mem_gnt | input | 1 | access completes this cycle |
| mem_rdata | input | 8 | read byte, valid with grant |
| irq | output | 1 | interrupt request |

## Verification
The bench targets the following corner cases:

- **Frame spilling across descriptors.** A frame longer than the buffer has to spill over. A design that got this wrong would either run past the buffer or mark the first fragment as an end of message.
- **Halt at the end address, then resume.** The ring reaches the end address and the host then resumes it with the end address wrapped around. An engine that skipped the compare would overwrite descriptors the host still owns. One that lost its position would resume at the wrong descriptor.
- **Halt mid-frame, and abort mid-frame.** A halt in the middle of a frame must keep the fill offset. An abort in the middle of a frame must drop it. Confusing the two shows up as misplaced buffer writes.
- **Counter wrap, clear qualifier and masked interrupts.** The bench runs 256 frames to wrap the frame counter. It also checks the clear qualifier and interrupt masking, which catches flags that clear the enable bit or fire while masked.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RECV,
        ST_WRITE,
        ST_WBACK
    } eng_st_e;

    localparam int RX_ERR_W = 5;

    localparam logic [2:0] RA_CUR  = 3'd0;
    localparam logic [2:0] RA_END  = 3'd1;
    localparam logic [2:0] RA_BLEN = 3'd2;
    localparam logic [2:0] RA_CSR  = 3'd3;
    localparam logic [2:0] RA_IEN  = 3'd4;
    localparam logic [2:0] RA_FCNT = 3'd5;
    localparam logic [2:0] RA_CMD  = 3'd6;

    localparam int CSR_EN   = 0;
    localparam int CSR_QUAL = 1;
    localparam int CSR_EOT  = 2;
    localparam int CSR_EOM  = 3;
    localparam int CSR_BOF  = 4;
    localparam int CSR_COF  = 5;
endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16,
    parameter int FCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              cda_ld_i,
    input  logic [ADDR_W-1:0] cda_nxt_i,
    input  logic              set_eom_i,
    input  logic              set_bof_i,
    output logic              en_o,
    output logic              abort_o,
    output logic [ADDR_W-1:0] cda_o,
    output logic [ADDR_W-1:0] eda_o,
    output logic [LEN_W-1:0]  buflen_o,
    output logic              irq
);
    localparam logic [FCNT_W-1:0] FCNT_MAX = {FCNT_W{1'b1}};

    typedef struct packed {
        logic              en;
        logic              eot;
        logic              eom;
        logic              bof;
        logic              cof;
        logic [1:0]        ie;
        logic [FCNT_W-1:0] fcnt;
        logic [ADDR_W-1:0] cda;
        logic [ADDR_W-1:0] eda;
        logic [LEN_W-1:0]  buflen;
    } regs_t;

    regs_t r_q, r_d;
    logic  abort_cmd;

    assign abort_cmd = reg_we && (reg_addr == RA_CMD) && reg_wdata[0];

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            case (reg_addr)
                RA_CUR:  r_d.cda    = reg_wdata;
                RA_END:  r_d.eda    = reg_wdata;
                RA_BLEN: r_d.buflen = reg_wdata[LEN_W-1:0];
                RA_CSR: begin
                    if (reg_wdata[CSR_QUAL]) begin
                        if (reg_wdata[CSR_EOT]) r_d.eot = 1'b0;
                        if (reg_wdata[CSR_EOM]) r_d.eom = 1'b0;
                        if (reg_wdata[CSR_BOF]) r_d.bof = 1'b0;
                        if (reg_wdata[CSR_COF]) r_d.cof = 1'b0;
                    end else begin
                        r_d.en = reg_wdata[CSR_EN];
                    end
                end
                RA_IEN:  r_d.ie = reg_wdata[1:0];
                RA_CMD:  if (reg_wdata[1]) r_d.fcnt = '0;
                default: ;
            endcase
        end
        if (cda_ld_i) r_d.cda = cda_nxt_i;
        if (set_eom_i) begin
            r_d.eom  = 1'b1;
            r_d.fcnt = r_q.fcnt + 1'b1;
            if (r_q.fcnt == FCNT_MAX) r_d.cof = 1'b1;
        end
        if (set_bof_i) begin
            r_d.bof = 1'b1;
            r_d.eot = 1'b1;
            r_d.en  = 1'b0;
        end
        if (abort_cmd) begin
            r_d.en  = 1'b0;
            r_d.eot = 1'b0;
            r_d.eom = 1'b0;
            r_d.bof = 1'b0;
            r_d.cof = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CUR:  reg_rdata = r_q.cda;
            RA_END:  reg_rdata = r_q.eda;
            RA_BLEN: reg_rdata = ADDR_W'(r_q.buflen);
            RA_CSR:  reg_rdata = ADDR_W'({r_q.cof, r_q.bof, r_q.eom, r_q.eot, 1'b0, r_q.en});
            RA_IEN:  reg_rdata = ADDR_W'(r_q.ie);
            RA_FCNT: reg_rdata = ADDR_W'(r_q.fcnt);
            default: reg_rdata = '0;
        endcase
    end

    assign en_o     = r_q.en;
    assign abort_o  = abort_cmd;
    assign cda_o    = r_q.cda;
    assign eda_o    = r_q.eda;
    assign buflen_o = r_q.buflen;
    assign irq      = (r_q.eom & r_q.ie[0]) | (r_q.bof & r_q.ie[1]);

    // R6: an overflow flag never appears while the channel stays enabled
    p_bof_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.bof && !$past(r_q.bof)) |-> !r_q.en);

    // R10: the frame counter only steps by one or returns to zero
    p_fcnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fcnt != $past(r_q.fcnt)) |->
            ((r_q.fcnt == $past(r_q.fcnt) + 1'b1) || (r_q.fcnt == '0)));
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                abort_i,
    input  logic [ADDR_W-1:0]   cda_i,
    input  logic [ADDR_W-1:0]   eda_i,
    input  logic [LEN_W-1:0]    buflen_i,
    input  logic                rx_valid,
    output logic                rx_ready,
    input  logic [7:0]          rx_data,
    input  logic                rx_eof,
    input  logic [RX_ERR_W-1:0] rx_err,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [7:0]          mem_wdata,
    input  logic                mem_gnt,
    input  logic [7:0]          mem_rdata,
    output logic                cda_ld_o,
    output logic [ADDR_W-1:0]   cda_nxt_o,
    output logic                set_eom_o,
    output logic                set_bof_o
);
    localparam int AB      = ADDR_W / 8;
    localparam int LB      = LEN_W / 8;
    localparam int FETCH_N = 2 * AB;
    localparam int WB_N    = LB + 1;
    localparam int IW      = $clog2(FETCH_N + WB_N);

    typedef struct packed {
        eng_st_e             st;
        logic [IW-1:0]       idx;
        logic [ADDR_W-1:0]   chain;
        logic [ADDR_W-1:0]   bufp;
        logic [LEN_W-1:0]    cnt;
        logic [7:0]          dbyte;
        logic                last;
        logic [RX_ERR_W-1:0] errs;
    } eng_t;

    eng_t e_q, e_d;
    logic [LEN_W-1:0] cnt_inc;
    logic [7:0]       stat_byte;

    assign cnt_inc   = e_q.cnt + 1'b1;
    assign stat_byte = e_q.last ? 8'({e_q.errs, 1'b1}) : 8'h00;

    always_comb begin
        e_d       = e_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rx_ready  = 1'b0;
        cda_ld_o  = 1'b0;
        set_eom_o = 1'b0;
        set_bof_o = 1'b0;
        case (e_q.st)
            ST_IDLE: begin
                if (en_i) begin
                    if (cda_i == eda_i) begin
                        set_bof_o = 1'b1;
                    end else begin
                        e_d.st  = ST_FETCH;
                        e_d.idx = '0;
                    end
                end
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cda_i + ADDR_W'(e_q.idx);
                if (mem_gnt) begin
                    if (e_q.idx < IW'(AB)) e_d.chain = {mem_rdata, e_q.chain[ADDR_W-1:8]};
                    else                   e_d.bufp  = {mem_rdata, e_q.bufp[ADDR_W-1:8]};
                    if (e_q.idx == IW'(FETCH_N - 1)) begin
                        e_d.st  = ST_RECV;
                        e_d.idx = '0;
                    end else begin
                        e_d.idx = e_q.idx + 1'b1;
                    end
                end
            end
            ST_RECV: begin
                rx_ready = en_i;
                if (en_i && rx_valid) begin
                    e_d.dbyte = rx_data;
                    e_d.last  = rx_eof;
                    e_d.errs  = rx_err;
                    e_d.st    = ST_WRITE;
                end
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = e_q.bufp + ADDR_W'(e_q.cnt);
                mem_wdata = e_q.dbyte;
                if (mem_gnt) begin
                    e_d.cnt = cnt_inc;
                    if (e_q.last || (cnt_inc == buflen_i)) begin
                        e_d.st  = ST_WBACK;
                        e_d.idx = '0;
                    end else begin
                        e_d.st = ST_RECV;
                    end
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cda_i + ADDR_W'(FETCH_N) + ADDR_W'(e_q.idx);
                mem_wdata = (e_q.idx < IW'(LB)) ? 8'(e_q.cnt >> (8 * e_q.idx)) : stat_byte;
                if (mem_gnt) begin
                    if (e_q.idx == IW'(WB_N - 1)) begin
                        cda_ld_o  = 1'b1;
                        set_eom_o = e_q.last;
                        e_d.st    = ST_IDLE;
                        e_d.cnt   = '0;
                        e_d.last  = 1'b0;
                    end else begin
                        e_d.idx = e_q.idx + 1'b1;
                    end
                end
            end
            default: e_d.st = ST_IDLE;
        endcase
        if (abort_i) begin
            e_d.st   = ST_IDLE;
            e_d.idx  = '0;
            e_d.cnt  = '0;
            e_d.last = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{st: ST_IDLE, default: '0};
        else        e_q <= e_d;
    end

    assign cda_nxt_o = e_q.chain;

    // R12: a waiting access keeps its request and its content
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !abort_i) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R5: a payload write never lands at or beyond the buffer length
    p_buf_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && (e_q.st == ST_WRITE)) |-> (e_q.cnt < buflen_i));

    // R6: a descriptor fetch only starts when the end address was not reached
    p_fetch_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((e_q.st == ST_FETCH) && ($past(e_q.st) == ST_IDLE)) |->
            ($past(cda_i) != $past(eda_i)));
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16,
    parameter int FCNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [2:0]          reg_addr,
    input  logic [ADDR_W-1:0]   reg_wdata,
    output logic [ADDR_W-1:0]   reg_rdata,
    input  logic                rx_valid,
    output logic                rx_ready,
    input  logic [7:0]          rx_data,
    input  logic                rx_eof,
    input  logic [RX_ERR_W-1:0] rx_err,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [7:0]          mem_wdata,
    input  logic                mem_gnt,
    input  logic [7:0]          mem_rdata,
    output logic                irq
);
    logic              en, abort, cda_ld, set_eom, set_bof;
    logic [ADDR_W-1:0] cda, eda, cda_nxt;
    logic [LEN_W-1:0]  buflen;

    rdma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .FCNT_W(FCNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cda_ld_i  (cda_ld),
        .cda_nxt_i (cda_nxt),
        .set_eom_i (set_eom),
        .set_bof_i (set_bof),
        .en_o      (en),
        .abort_o   (abort),
        .cda_o     (cda),
        .eda_o     (eda),
        .buflen_o  (buflen),
        .irq       (irq)
    );

    rdma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .abort_i   (abort),
        .cda_i     (cda),
        .eda_i     (eda),
        .buflen_i  (buflen),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .rx_data   (rx_data),
        .rx_eof    (rx_eof),
        .rx_err    (rx_err),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata),
        .cda_ld_o  (cda_ld),
        .cda_nxt_o (cda_nxt),
        .set_eom_o (set_eom),
        .set_bof_o (set_bof)
    );
endmodule

// File: tb/rx_desc_dma_test.sv
module rx_desc_dma_test;
    localparam int CLK_PERIOD = 10;
    localparam int BUFLEN     = 8;
    localparam int NDESC      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = '0;
    logic        rx_eof = 1'b0;
    logic [4:0]  rx_err = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_desc_dma uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_eof(rx_eof), .rx_err(rx_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq)
    );

    typedef struct {
        logic [15:0] a;
        logic [7:0]  d;
        string       tag;
    } exp_t;

    exp_t        q_exp[$];
    exp_t        e_cur;
    logic [7:0]  mem [0:4095];
    int          n_chk = 0;
    int          n_bad = 0;
    int          gcnt  = 0;
    bit          done  = 1'b0;
    int          m_d   = 0;
    int          m_cnt = 0;

    function automatic logic [15:0] desc_a(input int i);
        return 16'h0100 + 16'(8 * i);
    endfunction
    function automatic logic [15:0] buf_a(input int i);
        return 16'h0400 + 16'(64 * i);
    endfunction

    // memory responder and scoreboard monitor
    always @(negedge clk) begin
        gcnt++;
        mem_gnt = 1'b0;
        if (mem_req && (gcnt % 3 != 0)) begin
            mem_gnt   = 1'b1;
            mem_rdata = mem[mem_addr[11:0]];
            if (mem_we) begin
                mem[mem_addr[11:0]] = mem_wdata;
                n_chk++;
                if (q_exp.size() == 0) begin
                    n_bad++;
                    $display("FAIL R12 unexpected write: actual %h@%h expected none", mem_wdata, mem_addr);
                end else begin
                    e_cur = q_exp.pop_front();
                    if (mem_addr !== e_cur.a || mem_wdata !== e_cur.d) begin
                        n_bad++;
                        $display("FAIL %s write: actual %h@%h expected %h@%h",
                                 e_cur.tag, mem_wdata, mem_addr, e_cur.d, e_cur.a);
                    end
                end
            end
        end
    end

    function automatic void push(input logic [15:0] a, input logic [7:0] d, input string tag);
        exp_t x;
        x.a = a; x.d = d; x.tag = tag;
        q_exp.push_back(x);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_byte(input logic [7:0] d, input logic eof, input logic [4:0] err);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_eof = eof; rx_err = err;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0; rx_err = '0;
    endtask

    // driver: pushes the expected writes, then feeds the bytes
    task automatic send_frame(input int n, input logic [4:0] err, input logic [7:0] base,
                              input bit fin, input string tag);
        for (int k = 0; k < n; k++) begin
            bit lastb;
            lastb = fin && (k == n - 1);
            push(buf_a(m_d) + 16'(m_cnt), base + 8'(k), tag);
            m_cnt++;
            if (lastb || m_cnt == BUFLEN) begin
                push(desc_a(m_d) + 16'd4, 8'(m_cnt), "R4");
                push(desc_a(m_d) + 16'd5, 8'(m_cnt >> 8), "R4");
                push(desc_a(m_d) + 16'd6, lastb ? {2'b00, err, 1'b1} : 8'h00, lastb ? "R4" : "R5");
                m_d   = (m_d + 1) % NDESC;
                m_cnt = 0;
            end
            put_byte(base + 8'(k), lastb, lastb ? err : 5'd0);
        end
    endtask

    task automatic drain();
        while (q_exp.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic stall_check(input string tag);
        bit bad;
        bad = 1'b0;
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'hEE;
        repeat (10) begin
            @(negedge clk);
            if (rx_ready || mem_req) bad = 1'b1;
        end
        rx_valid = 1'b0;
        chk(tag, {15'd0, bad}, 16'd0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        for (int i = 0; i < NDESC; i++) begin
            mem[desc_a(i)]     = desc_a((i + 1) % NDESC) & 8'hFF;
            mem[desc_a(i) + 1] = desc_a((i + 1) % NDESC) >> 8;
            mem[desc_a(i) + 2] = buf_a(i) & 8'hFF;
            mem[desc_a(i) + 3] = buf_a(i) >> 8;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd3, v); chk("R1 csr", v, 16'h0000);
        rd(3'd5, v); chk("R1 fcnt", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 mem_req/rx_ready", {14'd0, mem_req, rx_ready}, 16'd0);

        // setup: ring of 4, end at descriptor 3
        wr(3'd0, desc_a(0));
        wr(3'd1, desc_a(3));
        wr(3'd2, 16'(BUFLEN));
        wr(3'd4, 16'h0003);
        wr(3'd3, 16'h0001);

        // R2 R4 single frame
        send_frame(5, 5'd0, 8'h10, 1'b1, "R2");
        drain();
        rd(3'd0, v); chk("R3 cda after frame", v, desc_a(1));
        rd(3'd3, v); chk("R4 csr eom", v, 16'h0009);
        rd(3'd5, v); chk("R10 fcnt one", v, 16'd1);
        chk("R9 irq on eom", {15'd0, irq}, 16'd1);
        wr(3'd3, 16'h000A);
        rd(3'd3, v); chk("R7 qualified clear keeps enable", v, 16'h0001);
        chk("R9 irq after clear", {15'd0, irq}, 16'd0);

        // R5 spill with CRC error, then R6 halt at end address
        send_frame(11, 5'b00001, 8'h20, 1'b1, "R5");
        drain();
        rd(3'd3, v); chk("R6 csr halted", v, 16'h001C);
        rd(3'd0, v); chk("R6 cda at end", v, desc_a(3));
        chk("R9 irq on bof", {15'd0, irq}, 16'd1);
        stall_check("R6 no transfer when halted");

        // R13 resume after moving the end address
        wr(3'd1, desc_a(1));
        wr(3'd3, 16'h0016);
        rd(3'd3, v); chk("R7 unqualified flags stay", v, 16'h0008);
        wr(3'd3, 16'h0001);
        send_frame(4, 5'd0, 8'h30, 1'b1, "R13");
        send_frame(2, 5'b10000, 8'h40, 1'b1, "R3");
        drain();
        rd(3'd0, v); chk("R3 wrap to first then halt", v, desc_a(1));
        rd(3'd3, v); chk("R13 halted again", v, 16'h001C);

        // R8 halt mid-frame keeps the offset
        wr(3'd3, 16'h003E);
        wr(3'd1, desc_a(0));
        wr(3'd3, 16'h0001);
        send_frame(2, 5'd0, 8'h50, 1'b0, "R8");
        drain();
        wr(3'd3, 16'h0000);
        stall_check("R8 no byte taken while disabled");
        rd(3'd3, v); chk("R8 csr disabled", v, 16'h0000);
        wr(3'd3, 16'h0001);
        send_frame(1, 5'b00100, 8'h52, 1'b1, "R8");
        drain();

        // R11 abort drops the partial buffer
        send_frame(2, 5'd0, 8'h60, 1'b0, "R11");
        drain();
        wr(3'd6, 16'h0001);
        rd(3'd3, v); chk("R11 csr after abort", v, 16'h0000);
        m_cnt = 0;
        wr(3'd3, 16'h0001);
        send_frame(1, 5'b00001, 8'h70, 1'b1, "R11");
        drain();
        rd(3'd0, v); chk("R11 cda after refill", v, desc_a(3));
        rd(3'd5, v); chk("R10 one count per frame", v, 16'd6);
        wr(3'd6, 16'h0002);
        rd(3'd5, v); chk("R10 clear command", v, 16'd0);

        // R10 counter wrap, R9 masked interrupt
        wr(3'd4, 16'h0000);
        wr(3'd3, 16'h003E);
        wr(3'd1, 16'hFFF0);
        wr(3'd3, 16'h0001);
        for (int i = 0; i < 256; i++) send_frame(1, 5'd0, 8'(i), 1'b1, "R3");
        drain();
        rd(3'd5, v); chk("R10 counter wrapped", v, 16'd0);
        rd(3'd3, v); chk("R10 cof set", v, 16'h0029);
        chk("R9 irq masked", {15'd0, irq}, 16'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule